// File: doc/BRIEF.md
# Command/Response Serial Master

This block is a half-duplex serial master that runs one command/response transaction per frame. A command word arrives on a parallel valid/ready port. The block raises the frame line, sends the command on the transmit line most significant bit first, then clocks in a response word from the receive line, also most significant bit first. The frame line stays active across both phases. The command is 8 or 16 bits long and the response is 4 to 32 bits long. Both lengths are taken from the configuration inputs when the command is accepted.

The serial clock comes from the system clock through a divider. Each half period of the serial clock lasts `DIV` system clocks, and the clock rests low between transactions. The master changes its transmit data after a falling serial clock edge and samples receive data on the rising edge. When the response is complete, it is presented right-aligned on a 32-bit output together with a one-cycle valid strobe.

There are two framing modes. In single mode the frame drops after every transaction. In continuous mode the frame stays active between transactions and the next command starts without a gap in the frame.

Top module: `mw_cmd_master`

## Requirements
- R1: After reset, `frame`, `sclk`, `txd` and `rsp_valid` are low and `cmd_ready` is high.
- R2: An accepted command is sent on `txd` most significant bit first. With `cfg_cmd16`=1 the block sends `cmd_word[15:0]`; with `cfg_cmd16`=0 it sends `cmd_word[7:0]` and ignores `cmd_word[15:8]`. `txd` never changes on a rising `sclk` edge.
- R3: After the command, the response is sampled from `rxd` on Nd rising `sclk` edges, first bit received being the most significant. It is delivered right-aligned in `rsp_data`, with all bits above Nd equal to zero.
- R4: `txd` is low throughout the response phase.
- R5: In single mode (`cfg_continuous`=0), `frame` is high from the cycle after the command is accepted until the final falling `sclk` edge. It drops together with the rise of `rsp_valid`.
- R6: `rsp_valid` is a one-cycle pulse. It rises 2·DIV·(Nc+Nd) system cycles after the accepting clock edge, where Nc is 8 or 16.
- R7: In continuous mode, `frame` stays high after a transaction ends and a new command starts without dropping it. Clearing `cfg_continuous` while waiting drops `frame` one cycle later.
- R8: `rxd` is ignored during the command phase and while no transaction runs.
- R9: `cmd_ready` is low while a transaction runs, and `cmd_valid` has no effect during that time.
- R10: An effective response length below 4 is raised to 4, and one above 32 is lowered to 32.
- R11: `sclk` rests low. Within a transaction it produces exactly Nc+Nd rising edges. The k-th rising edge falls DIV·(2k−1) cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Master can accept a command |
| cmd_word | input | 16 | Command to send (low byte only in 8-bit mode) |
| cfg_cmd16 | input | 1 | 1: 16-bit command, 0: 8-bit command |
| cfg_data_len | input | 6 | Response length in bits (clamped to 4..32) |
| cfg_continuous | input | 1 | 1: keep frame active between transactions |
| rsp_data | output | 32 | Received response, right-aligned |
| rsp_valid | output | 1 | One-cycle strobe marking new `rsp_data` |
| sclk | output | 1 | Serial clock, idle low |
| frame | output | 1 | Frame, active high |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The clock edge that accepts a command is cycle zero. From there, the k-th rising `sclk` edge is due at cycle DIV·(2k−1), the response phase starts at falling edge Nc, and `rsp_valid` together with the frame end is due at cycle 2·DIV·(Nc+Nd). Every scenario task counts falling system-clock edges from the accepting edge and compares each observation with these cycle numbers. It also models the slave: it reads `txd` on rising serial edges and changes `rxd` only after falling ones. Because all sampling is done mid-cycle, each check reads registered outputs after they have settled.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int CMD_W  = 16;
    localparam int DATA_W = 32;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_RSP,
        ST_HOLD
    } mw_state_e;

    typedef struct packed {
        mw_state_e            st;
        logic                 sclk;
        logic                 txd;
        logic                 frame;
        logic [CMD_W-1:0]     tx_sh;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     nd_m1;
        logic [DATA_W-1:0]    rx_sh;
        logic [DATA_W-1:0]    rsp;
        logic                 rsp_vld;
    } mw_regs_t;
endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/mw_len_sel.sv
module mw_len_sel
    import mw_pkg::*;
(
    input  logic             cmd16,
    input  logic [5:0]       data_len,
    output logic [CNT_W-1:0] cmd_m1,
    output logic [CNT_W-1:0] data_m1
);
    always_comb begin
        cmd_m1 = cmd16 ? CNT_W'(15) : CNT_W'(7);
        if (data_len < 6'd4)
            data_m1 = CNT_W'(3);
        else if (data_len > 6'(DATA_W))
            data_m1 = CNT_W'(DATA_W - 1);
        else
            data_m1 = CNT_W'(data_len - 6'd1);
    end
endmodule

// File: rtl/mw_cmd_master.sv
module mw_cmd_master
    import mw_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [15:0] cmd_word,
    input  logic        cfg_cmd16,
    input  logic [5:0]  cfg_data_len,
    input  logic        cfg_continuous,
    output logic [31:0] rsp_data,
    output logic        rsp_valid,
    output logic        sclk,
    output logic        frame,
    output logic        txd,
    input  logic        rxd
);
    mw_regs_t r_d, r_q;
    logic tick;
    logic run;
    logic [CNT_W-1:0] cmd_m1, data_m1;
    logic rsp_phase;

    assign run       = (r_q.st == ST_CMD) || (r_q.st == ST_RSP);
    assign rsp_phase = (r_q.st == ST_RSP);

    mw_half_tick #(.DIV(DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    mw_len_sel len_i (
        .cmd16    (cfg_cmd16),
        .data_len (cfg_data_len),
        .cmd_m1   (cmd_m1),
        .data_m1  (data_m1)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rsp_vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_HOLD: begin
                if (cmd_valid) begin
                    r_d.st    = ST_CMD;
                    r_d.frame = 1'b1;
                    r_d.sclk  = 1'b0;
                    r_d.tx_sh = cfg_cmd16 ? cmd_word : {cmd_word[7:0], 8'h00};
                    r_d.txd   = cfg_cmd16 ? cmd_word[15] : cmd_word[7];
                    r_d.cnt   = cmd_m1;
                    r_d.nd_m1 = data_m1;
                    r_d.rx_sh = '0;
                end else if (r_q.st == ST_HOLD && !cfg_continuous) begin
                    r_d.st    = ST_IDLE;
                    r_d.frame = 1'b0;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.cnt == '0) begin
                            r_d.st  = ST_RSP;
                            r_d.txd = 1'b0;
                            r_d.cnt = r_q.nd_m1;
                        end else begin
                            r_d.cnt   = r_q.cnt - 1'b1;
                            r_d.tx_sh = {r_q.tx_sh[CMD_W-2:0], 1'b0};
                            r_d.txd   = r_q.tx_sh[CMD_W-2];
                        end
                    end
                end
            end
            ST_RSP: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk  = 1'b1;
                        r_d.rx_sh = {r_q.rx_sh[DATA_W-2:0], rxd};
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.cnt == '0) begin
                            r_d.rsp     = r_q.rx_sh;
                            r_d.rsp_vld = 1'b1;
                            r_d.st      = cfg_continuous ? ST_HOLD : ST_IDLE;
                            r_d.frame   = cfg_continuous;
                        end else begin
                            r_d.cnt = r_q.cnt - 1'b1;
                        end
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE) || (r_q.st == ST_HOLD);
    assign rsp_data  = r_q.rsp;
    assign rsp_valid = r_q.rsp_vld;
    assign sclk      = r_q.sclk;
    assign frame     = r_q.frame;
    assign txd       = r_q.txd;
endmodule

// File: rtl/mw_cmd_master_chk.sv
module mw_cmd_master_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic frame,
    input logic txd,
    input logic rsp_valid,
    input logic cmd_ready,
    input logic rsp_phase
);
    // R1: with the frame inactive the serial lines rest low
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !frame |-> (!sclk && !txd));

    // R2: transmit data never moves on a rising serial edge
    a_r2_txd_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(txd));

    // R4: transmit line low during the response phase
    a_r4_txd_low_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_phase |-> !txd);

    // R6: valid strobe lasts a single cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: no command accepted while the serial clock is high
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cmd_ready);

    // R11: serial clock only runs inside a frame
    a_r11_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> frame);
endmodule

bind mw_cmd_master mw_cmd_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .frame     (frame),
    .txd       (txd),
    .rsp_valid (rsp_valid),
    .cmd_ready (cmd_ready),
    .rsp_phase (rsp_phase)
);

// File: tb/mw_cmd_master_tb_top.sv
module mw_cmd_master_tb_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_word = '0;
    logic        cfg_cmd16 = 1'b0;
    logic [5:0]  cfg_data_len = 6'd8;
    logic        cfg_continuous = 1'b0;
    logic [31:0] rsp_data;
    logic        rsp_valid;
    logic        sclk;
    logic        frame;
    logic        txd;
    logic        rxd = 1'b0;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mw_cmd_master #(.DIV(DIV)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_word       (cmd_word),
        .cfg_cmd16      (cfg_cmd16),
        .cfg_data_len   (cfg_data_len),
        .cfg_continuous (cfg_continuous),
        .rsp_data       (rsp_data),
        .rsp_valid      (rsp_valid),
        .sclk           (sclk),
        .frame          (frame),
        .txd            (txd),
        .rxd            (rxd)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int len);
        if (len < 4) return 4;
        if (len > 32) return 32;
        return len;
    endfunction

    // One transaction: drives the command, models the slave, checks timing and results.
    task automatic xfer(input logic [15:0] w, input bit c16, input int len,
                        input logic [31:0] data, input bit cont, input bit poke,
                        input string tag);
        int nc = c16 ? 16 : 8;
        int nd = eff_len(len);
        int t_end = 2 * (nc + nd) * DIV;
        logic [15:0] cap = '0;
        logic [15:0] exp_cmd = c16 ? w : {8'h00, w[7:0]};
        logic [31:0] mask = (nd == 32) ? 32'hFFFF_FFFF : ((32'd1 << nd) - 1);
        int rises = 0, falls = 0, per_err = 0, txd_err = 0;
        int frm_err = 0, rdy_err = 0, early = 0;
        logic prev_s = 1'b0;
        @(negedge clk);
        cmd_word = w; cfg_cmd16 = c16; cfg_data_len = 6'(len);
        cfg_continuous = cont; cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, {tag, " R9 ready before accept"}, cmd_ready, 1);
        @(posedge clk);
        for (int c = 1; c <= t_end + 1; c++) begin
            @(negedge clk);
            if (c == 1) begin
                cmd_valid = poke;
                cmd_word  = poke ? ~w : w;
            end
            if (c == t_end) cmd_valid = 1'b0;
            if (sclk && !prev_s) begin
                rises++;
                if (rises <= nc) cap = {cap[14:0], txd};
                if (c - 1 != DIV * (2 * rises - 1)) per_err++;
            end
            if (!sclk && prev_s) falls++;
            prev_s = sclk;
            if (falls >= nc && falls < nc + nd) rxd = data[nd - 1 - (falls - nc)];
            else rxd = 1'($urandom);
            if (c <= t_end) begin
                if (falls >= nc && txd) txd_err++;
                if (!frame) frm_err++;
                if (cmd_ready) rdy_err++;
                if (rsp_valid) early++;
            end
        end
        chk(cap == exp_cmd, {tag, " R2 command bits"}, cap, exp_cmd);
        chk(rsp_valid == 1'b1 && early == 0, {tag, " R6 valid timing"}, early, 0);
        chk(rsp_data == (data & mask), {tag, " R3 R8 R10 response"}, rsp_data, data & mask);
        chk(txd_err == 0, {tag, " R4 txd low in response"}, txd_err, 0);
        chk(frm_err == 0 && frame == cont, {tag, " R5 R7 frame span"}, frame, cont);
        chk(rdy_err == 0, {tag, " R9 busy"}, rdy_err, 0);
        chk(rises == nc + nd && per_err == 0, {tag, " R11 sclk edges"}, rises, nc + nd);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {tag, " R6 single pulse"}, rsp_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!frame && !sclk && !txd && !rsp_valid && cmd_ready,
            "R1 reset state", {frame, sclk, txd, rsp_valid, cmd_ready}, 5'b00001);
    endtask

    task automatic t_idle_rxd();
        int hits = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rxd = ~rxd;
            if (rsp_valid || frame || sclk) hits++;
        end
        chk(hits == 0, "R8 idle rxd ignored", hits, 0);
    endtask

    task automatic t_continuous();
        xfer(16'hA55A, 1'b1, 12, 32'h0000_0ABC, 1'b1, 1'b0, "cont1");
        chk(frame == 1'b1, "R7 frame held between", frame, 1);
        xfer(16'h00C3, 1'b0, 8, 32'h0000_005E, 1'b1, 1'b0, "cont2");
        @(negedge clk);
        cfg_continuous = 1'b0;
        @(negedge clk);
        chk(frame == 1'b0, "R7 frame drops when cleared", frame, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        xfer(16'hFF96, 1'b0, 12, 32'h0000_0A5C, 1'b0, 1'b0, "c8d12");
        xfer(16'hB1E7, 1'b1, 32, 32'hDEAD_BEEF, 1'b0, 1'b0, "c16d32");
        xfer(16'h0081, 1'b0, 4, 32'h0000_0009, 1'b0, 1'b0, "c8d4");
        xfer(16'h3C3C, 1'b1, 2, 32'h0000_000B, 1'b0, 1'b0, "R10 clamp low");
        xfer(16'h0042, 1'b0, 50, 32'h8765_4321, 1'b0, 1'b0, "R10 clamp high");
        xfer(16'h005A, 1'b0, 16, 32'h0000_F00D, 1'b0, 1'b1, "R9 poke busy");
        t_idle_rxd();
        t_continuous();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule